// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block answers the processor's interrupt-acknowledge cycles on behalf of an interrupt controller. A priority resolver elsewhere presents the winning request level. Each acknowledge pulse arrives as an active-low strobe. The sequencer counts these pulses and places the right byte on a data-out bus while the strobe is held. It also raises a drive-enable flag for as long as that byte is valid, and sends the resolver a one-cycle pulse that tells it to mark the level as in service.

The block has two answer formats. In vectored mode the sequence has two pulses. The first pulse only freezes the level, and the second pulse returns an 8-bit vector: the programmed base with the level in its three low bits. In call mode the sequence has three pulses, returning a call opcode (0xCD), then the low byte of a handler address, then the high byte. The low address byte takes its upper bits from a programmed byte and places the level at bits 4:2 when handlers are 4 bytes apart, or at bits 5:3 when they are 8 bytes apart. The strobe is synchronised into the clock domain, and pulses are counted on its assertion edges.

Top module: `intack_vector_seq`

## Requirements
- R1: After a synchronous reset, drive_en, isr_latch and data_out are all 0 and the sequence is idle, so the next pulse is treated as the first one, even if reset came in the middle of a sequence.
- R2: In vectored mode (call_mode=0), the first pulse of a sequence drives nothing: drive_en stays 0 and data_out stays 0x00.
- R3: In vectored mode, the second pulse drives data_out = {vec_base[7:3], level} with drive_en=1.
- R4: In call mode (call_mode=1), the first pulse drives the opcode 0xCD with drive_en=1, in the same cycle as the isr_latch pulse.
- R5: In call mode with interval8=0 (4-byte spacing), the second pulse drives {addr_lo[7:5], level, 2'b00}.
- R6: In call mode with interval8=1 (8-byte spacing), the second pulse drives {addr_lo[7:6], level, 3'b000}.
- R7: In call mode, the third pulse drives addr_hi unchanged.
- R8: The level, the mode and the interval are captured at the first pulse. Changes to these inputs later in the sequence have no effect on the bytes that follow.
- R9: drive_en is 1 only while a byte is being driven for an asserted strobe. It returns to 0 within SYNC_STAGES+2 cycles after the strobe is released. data_out is 0x00 whenever drive_en is 0.
- R10: After the last pulse of a sequence (the second in vectored mode, the third in call mode), the sequencer returns to idle, and the next pulse starts a new sequence.
- R11: isr_latch is high for exactly one cycle per sequence, on the first pulse only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ack_n | input | 1 | Acknowledge strobe from the processor, active low, asynchronous |
| req_level | input | 3 | Level currently resolved by the priority block |
| call_mode | input | 1 | 1 = three-byte call answer, 0 = two-pulse vectored answer |
| interval8 | input | 1 | Call-mode handler spacing: 1 = 8 bytes, 0 = 4 bytes |
| vec_base | input | 8 | Programmed vector base (bits 7:3 used) |
| addr_lo | input | 8 | Programmed low handler-address byte (upper bits used) |
| addr_hi | input | 8 | Programmed high handler-address byte |
| data_out | output | 8 | Byte driven during an acknowledge pulse, 0 otherwise |
| drive_en | output | 1 | High while data_out carries a driven byte |
| isr_latch | output | 1 | One-cycle pulse telling the resolver to set the in-service bit |

## Verification
In call mode, the first pulse does two things in the same registered cycle: it sends the in-service latch pulse and it starts driving the opcode. The bench provokes this on every call-mode sequence. At a single sample point it checks that isr_latch is high, drive_en is high and the byte is 0xCD, then counts the latch pulses over the rest of the sequence to confirm none follow. In vectored mode, the same sample point must show the latch pulse together with an idle bus. Every expected byte is computed in the bench from the base, the level and the interval, using masks and shifts, across sweeps of all eight levels and several bases.

// File: rtl/ivs_pkg.sv
package ivs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SECOND = 2'd1,
    PH_THIRD  = 2'd2
  } phase_t;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_OPCODE = 3'd1,
    SEL_VECTOR = 3'd2,
    SEL_LOW    = 3'd3,
    SEL_HIGH   = 3'd4
  } byte_sel_t;

endpackage

// File: rtl/ivs_strobe_sync.sv
module ivs_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_n,
  output logic assert_pulse,
  output logic release_pulse
);

  logic [STAGES-1:0] chain;
  logic              active_q;
  logic              active;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain    <= '1;
      active_q <= 1'b0;
    end else begin
      chain    <= {chain[STAGES-2:0], strobe_n};
      active_q <= active;
    end
  end

  assign active        = ~chain[STAGES-1];
  assign assert_pulse  = active & ~active_q;
  assign release_pulse = ~active & active_q;

endmodule

// File: rtl/ivs_byte_fmt.sv
module ivs_byte_fmt
  import ivs_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter int              LVL_W  = 3,
  parameter logic [DATA_W-1:0] OPCODE = 8'hCD
) (
  input  byte_sel_t          sel,
  input  logic [LVL_W-1:0]   level,
  input  logic               interval8,
  input  logic [DATA_W-1:0]  vec_base,
  input  logic [DATA_W-1:0]  addr_lo,
  input  logic [DATA_W-1:0]  addr_hi,
  output logic [DATA_W-1:0]  byte_out
);

  localparam int SHIFT4 = 2;
  localparam int SHIFT8 = 3;
  localparam logic [DATA_W-1:0] ONE    = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] KEEP_V = ~((ONE << LVL_W) - ONE);
  localparam logic [DATA_W-1:0] KEEP_4 = ~((ONE << (LVL_W + SHIFT4)) - ONE);
  localparam logic [DATA_W-1:0] KEEP_8 = ~((ONE << (LVL_W + SHIFT8)) - ONE);

  logic [DATA_W-1:0] lvl_wide;
  logic [DATA_W-1:0] vector_byte;
  logic [DATA_W-1:0] low_byte;
  logic [DATA_W-1:0] spaced [2];

  assign lvl_wide    = {{(DATA_W-LVL_W){1'b0}}, level};
  assign vector_byte = (vec_base & KEEP_V) | lvl_wide;

  for (genvar g = 0; g < 2; g++) begin : g_spacing
    localparam int SH = (g == 0) ? SHIFT4 : SHIFT8;
    localparam logic [DATA_W-1:0] KEEP = (g == 0) ? KEEP_4 : KEEP_8;
    assign spaced[g] = (addr_lo & KEEP) | (lvl_wide << SH);
  end

  assign low_byte = interval8 ? spaced[1] : spaced[0];

  always_comb begin
    unique case (sel)
      SEL_OPCODE: byte_out = OPCODE;
      SEL_VECTOR: byte_out = vector_byte;
      SEL_LOW:    byte_out = low_byte;
      SEL_HIGH:   byte_out = addr_hi;
      default:    byte_out = '0;
    endcase
  end

endmodule

// File: rtl/ivs_seq_fsm.sv
module ivs_seq_fsm
  import ivs_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             assert_pulse,
  input  logic             call_mode,
  input  logic             interval8,
  input  logic [LVL_W-1:0] req_level,
  output byte_sel_t        sel,
  output logic             fire,
  output logic             latch_now,
  output logic [LVL_W-1:0] level_held,
  output logic             interval_held
);

  phase_t phase_q, phase_d;
  logic   mode_q;

  always_comb begin
    phase_d   = phase_q;
    sel       = SEL_NONE;
    fire      = 1'b0;
    latch_now = 1'b0;
    if (assert_pulse) begin
      unique case (phase_q)
        PH_IDLE: begin
          latch_now = 1'b1;
          phase_d   = PH_SECOND;
          if (call_mode) begin
            sel  = SEL_OPCODE;
            fire = 1'b1;
          end
        end
        PH_SECOND: begin
          fire = 1'b1;
          if (mode_q) begin
            sel     = SEL_LOW;
            phase_d = PH_THIRD;
          end else begin
            sel     = SEL_VECTOR;
            phase_d = PH_IDLE;
          end
        end
        PH_THIRD: begin
          fire    = 1'b1;
          sel     = SEL_HIGH;
          phase_d = PH_IDLE;
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q       <= PH_IDLE;
      mode_q        <= 1'b0;
      level_held    <= '0;
      interval_held <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (latch_now) begin
        mode_q        <= call_mode;
        level_held    <= req_level;
        interval_held <= interval8;
      end
    end
  end

endmodule

// File: rtl/intack_vector_seq.sv
module intack_vector_seq
  import ivs_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                LVL_W       = 3,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] OPCODE      = 8'hCD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_n,
  input  logic [LVL_W-1:0]  req_level,
  input  logic              call_mode,
  input  logic              interval8,
  input  logic [DATA_W-1:0] vec_base,
  input  logic [DATA_W-1:0] addr_lo,
  input  logic [DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] data_out,
  output logic              drive_en,
  output logic              isr_latch
);

  logic              assert_pulse;
  logic              release_pulse;
  byte_sel_t         sel;
  logic              fire;
  logic              latch_now;
  logic [LVL_W-1:0]  level_held;
  logic              interval_held;
  logic [DATA_W-1:0] next_byte;

  ivs_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk           (clk),
    .rst           (rst),
    .strobe_n      (ack_n),
    .assert_pulse  (assert_pulse),
    .release_pulse (release_pulse)
  );

  ivs_seq_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .assert_pulse  (assert_pulse),
    .call_mode     (call_mode),
    .interval8     (interval8),
    .req_level     (req_level),
    .sel           (sel),
    .fire          (fire),
    .latch_now     (latch_now),
    .level_held    (level_held),
    .interval_held (interval_held)
  );

  ivs_byte_fmt #(.DATA_W(DATA_W), .LVL_W(LVL_W), .OPCODE(OPCODE)) u_fmt (
    .sel       (sel),
    .level     (level_held),
    .interval8 (interval_held),
    .vec_base  (vec_base),
    .addr_lo   (addr_lo),
    .addr_hi   (addr_hi),
    .byte_out  (next_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out  <= '0;
      drive_en  <= 1'b0;
      isr_latch <= 1'b0;
    end else begin
      isr_latch <= latch_now;
      if (fire) begin
        data_out <= next_byte;
        drive_en <= 1'b1;
      end else if (release_pulse) begin
        data_out <= '0;
        drive_en <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ivs_checker.sv
module ivs_checker #(
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] OPCODE      = 8'hCD
) (
  input logic              clk,
  input logic              rst,
  input logic              ack_n,
  input logic              call_mode,
  input logic [DATA_W-1:0] data_out,
  input logic              drive_en,
  input logic              isr_latch
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!drive_en && !isr_latch && data_out == '0));

  assert_latch_single_R11: assert property (@(posedge clk) disable iff (rst)
    isr_latch |=> !isr_latch);

  assert_call_opcode_with_latch_R4: assert property (@(posedge clk) disable iff (rst)
    (isr_latch && drive_en) |-> data_out == OPCODE);

  assert_idle_bus_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> data_out == '0);

  assert_drive_follows_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_en) |-> $past(!ack_n, SYNC_STAGES));

  assert_byte_held_R8: assert property (@(posedge clk) disable iff (rst)
    (drive_en && $past(drive_en) && !$past(isr_latch) && !isr_latch && $stable(ack_n))
      |-> ($stable(data_out) || $past(ack_n, SYNC_STAGES + 1) != $past(ack_n, SYNC_STAGES)));

  assert_vector_first_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (isr_latch && !$past(call_mode, SYNC_STAGES + 1) && !$past(call_mode, 1)
     && $stable(call_mode) && !call_mode && !$past(drive_en)) |-> !drive_en);

endmodule

bind intack_vector_seq ivs_checker #(
  .DATA_W      (DATA_W),
  .SYNC_STAGES (SYNC_STAGES),
  .OPCODE      (OPCODE)
) u_ivs_checker (
  .clk       (clk),
  .rst       (rst),
  .ack_n     (ack_n),
  .call_mode (call_mode),
  .data_out  (data_out),
  .drive_en  (drive_en),
  .isr_latch (isr_latch)
);

// File: tb/intack_vector_seq_test.sv
`timescale 1ns/1ps
module intack_vector_seq_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ack_n = 1'b1;
  logic [2:0] req_level = '0;
  logic       call_mode = 1'b0;
  logic       interval8 = 1'b0;
  logic [7:0] vec_base = '0;
  logic [7:0] addr_lo = '0;
  logic [7:0] addr_hi = '0;
  logic [7:0] data_out;
  logic       drive_en;
  logic       isr_latch;

  int checks = 0;
  int fails  = 0;
  int latch_total = 0;

  always #2 clk = ~clk;

  intack_vector_seq uut (
    .clk(clk), .rst(rst), .ack_n(ack_n), .req_level(req_level),
    .call_mode(call_mode), .interval8(interval8), .vec_base(vec_base),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .data_out(data_out),
    .drive_en(drive_en), .isr_latch(isr_latch)
  );

  always @(negedge clk) if (isr_latch) latch_total++;

  task automatic chk(input int actual, input int expected, input string tag);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // One acknowledge pulse; returns byte, enable and latch seen at the drive point.
  task automatic pulse(output logic [7:0] d, output logic de, output logic lt);
    @(negedge clk) ack_n = 1'b0;
    repeat (3) @(negedge clk);
    d = data_out; de = drive_en; lt = isr_latch;
    repeat (3) @(negedge clk);
    ack_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(int'(drive_en), 0, "R9 drive_en after release");
    chk(int'(data_out), 0, "R9 data_out after release");
  endtask

  function automatic logic [7:0] exp_vec(input logic [7:0] b, input int l);
    return (b & 8'hF8) | 8'(l);
  endfunction
  function automatic logic [7:0] exp_low(input logic [7:0] a, input int l, input logic i8);
    return i8 ? ((a & 8'hC0) | 8'(l << 3)) : ((a & 8'hE0) | 8'(l << 2));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic de, lt;
    int lt0;
    logic [7:0] bases [3] = '{8'h40, 8'h08, 8'hFF};
    logic [7:0] los   [3] = '{8'h20, 8'h40, 8'hFF};
    logic [7:0] his   [3] = '{8'h3B, 8'h2A, 8'h00};

    repeat (3) @(negedge clk);
    chk(int'(drive_en), 0, "R1 reset drive_en");
    chk(int'(data_out), 0, "R1 reset data_out");
    chk(int'(isr_latch), 0, "R1 reset isr_latch");
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // Vectored sweep
    for (int b = 0; b < 3; b++) begin
      for (int l = 0; l < 8; l++) begin
        call_mode = 1'b0; vec_base = bases[b]; req_level = 3'(l);
        lt0 = latch_total;
        pulse(d, de, lt);
        chk(int'(de), 0, "R2 first vectored pulse silent");
        chk(int'(d), 0, "R2 first vectored pulse byte");
        chk(int'(lt), 1, "R11 latch on first pulse");
        pulse(d, de, lt);
        chk(int'(de), 1, "R3 vector drive_en");
        chk(int'(d), int'(exp_vec(bases[b], l)), "R3 vector byte");
        chk(latch_total - lt0, 1, "R11 one latch per vectored sequence");
      end
    end

    // Call sweep, both spacings
    for (int i8 = 0; i8 < 2; i8++) begin
      for (int b = 0; b < 3; b++) begin
        for (int l = 0; l < 8; l++) begin
          call_mode = 1'b1; interval8 = i8[0]; addr_lo = los[b]; addr_hi = his[b];
          req_level = 3'(l);
          lt0 = latch_total;
          pulse(d, de, lt);
          chk(int'(d), 8'hCD, "R4 opcode");
          chk(int'({de, lt}), 3, "R4 opcode drive and latch same cycle");
          pulse(d, de, lt);
          chk(int'(d), int'(exp_low(los[b], l, i8[0])), i8 ? "R6 low byte spacing 8" : "R5 low byte spacing 4");
          chk(int'(lt), 0, "R11 no latch on second pulse");
          pulse(d, de, lt);
          chk(int'(d), int'(his[b]), "R7 high byte");
          chk(int'(de), 1, "R7 high byte drive_en");
          chk(latch_total - lt0, 1, "R11 one latch per call sequence");
        end
      end
    end

    // R8: vectored sequence, inputs changed after first pulse
    call_mode = 1'b0; vec_base = 8'h40; req_level = 3'd3;
    pulse(d, de, lt);
    req_level = 3'd6; call_mode = 1'b1;
    pulse(d, de, lt);
    chk(int'(d), 8'h43, "R8 held level and mode in vectored");
    // R10: next pulse starts a call sequence
    req_level = 3'd2; interval8 = 1'b0; addr_lo = 8'h20; addr_hi = 8'h3B;
    pulse(d, de, lt);
    chk(int'(lt), 1, "R10 new sequence after vectored end");
    chk(int'(d), 8'hCD, "R10 new call sequence opcode");
    req_level = 3'd7; interval8 = 1'b1; call_mode = 1'b0;
    pulse(d, de, lt);
    chk(int'(d), 8'h28, "R8 held level and interval in call");
    pulse(d, de, lt);
    chk(int'(d), 8'h3B, "R8 held mode gives third byte");
    call_mode = 1'b0; req_level = 3'd1;
    pulse(d, de, lt);
    chk(int'(lt), 1, "R10 new sequence after call end");
    pulse(d, de, lt);
    chk(int'(d), 8'h41, "R10 vector after restart");

    // R1: reset mid-sequence returns to idle
    call_mode = 1'b1; req_level = 3'd4;
    pulse(d, de, lt);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    call_mode = 1'b0; req_level = 3'd5;
    pulse(d, de, lt);
    chk(int'(lt), 1, "R1 reset mid-sequence restarts at first pulse");
    chk(int'(de), 0, "R1 first vectored pulse after reset silent");
    pulse(d, de, lt);
    chk(int'(d), 8'h45, "R1 vector after mid-sequence reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule